// File: doc/BRIEF.md
# Line Scan Serializing Buffer

This block collects one scan line of 16-bit words from a host bus, either through ordinary chip-select writes or through a DMA controller that answers a request line. It keeps up to 320 words in an internal line memory. On a start command it sends the line out as a serial bitstream. The bitstream begins with a programmable run of constant bits, which are all ones or all zeros, and then carries every stored word, most significant bit first. The words can be sent in the order they were written or in reverse order.

A command/data select input steers each host write. It goes either to the command registers or to the line memory. In internal clock mode, bits advance at the system clock divided by 1, 2, 4, 8 or 16, and a one-cycle strobe marks each new bit on the clock output pin. In external clock mode, each rising edge of a request clock from the receiving peripheral advances one bit. A clock enable input freezes the output. A busy output and an interrupt output tell the host when the line has been sent.

Top module: `lineSerializer`

## Requirements
- R1: After reset, busy, intr, dmaReq, serOut and clkOut are all 0, and the line memory is empty.
- R2: A write with chipSel=1 and cmdSel=1 is a command. The opcode is dataIn[15:13]: 0 loads the mode from dataIn[5:0], 1 loads the prefix length from dataIn[12:0], 2 loads the DMA word count from dataIn[8:0], and 3 starts a transmission. Mode bit 0 selects reverse order, bit 1 selects the external clock, bits 4:2 select the divider, and bit 5 sets the prefix level.
- R3: A write with chipSel=1 and cmdSel=0 appends dataIn to the line. Once 320 words are stored, further data writes are ignored.
- R4: A DMA count command with a nonzero value raises dmaReq. Each write with dmaAck=1 stores a word and lowers the count by one, and dmaReq falls once the count reaches zero. A count of zero raises no request.
- R5: The start command sets busy on the next cycle. The first bits sent are prefix-length copies of the prefix level.
- R6: In forward order, after the prefix, the words go out in write order, each with its most significant bit first.
- R7: In reverse order, the last written word goes out first, and the bits within each word are still sent most significant bit first.
- R8: In internal mode with a divider field d, the output advances one bit every 2^d cycles, and field values 5 to 7 act as 16. clkOut is high for one cycle each time a new bit appears.
- R9: In external mode, each rising edge of reqClk advances exactly one bit, and clkOut stays 0.
- R10: While clkEn is 0, serOut does not change and no bit is consumed.
- R11: The advance that follows the last bit ends the transmission: busy falls, intr rises, serOut returns to 0 and the line is emptied. Any later command write clears intr.
- R12: While busy, all host and DMA writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Host chip select |
| wrStb | input | 1 | Write strobe, sampled on the clock |
| cmdSel | input | 1 | 1 = command register write, 0 = line data write |
| dataIn | input | 16 | Write data |
| dmaAck | input | 1 | DMA acknowledge; qualifies a data write without chip select |
| dmaReq | output | 1 | DMA request, high while words remain to be requested |
| reqClk | input | 1 | External request clock from the peripheral |
| clkEn | input | 1 | Output shifting enable |
| serOut | output | 1 | Serial data out |
| clkOut | output | 1 | One-cycle strobe for each new bit in internal mode |
| busy | output | 1 | High while a line is being sent |
| intr | output | 1 | Set at the end of a line and cleared by a command write |

## Verification
The line is sent several ways: with a ones prefix and a zeros prefix, in forward and reverse order, at divider ratios 1, 4 and a saturated 16, and in external mode with clkEn stuttering. Together these separate the prefix level, the word order, the bit order and the bit timing. A full line of 322 writes shows whether the 320-word limit holds. An empty line with only a prefix exercises the end-of-line handling. Writes issued during a transmission show whether the ignore rule holds, because any leak would change the next bits or the next line. Loading the line through DMA shows whether the request falls at the right count.

// File: rtl/lsbPkg.sv
package lsbPkg;

  typedef enum logic [2:0] {
    OP_MODE = 3'd0,
    OP_PLEN = 3'd1,
    OP_DMA  = 3'd2,
    OP_GO   = 3'd3
  } cmdOpE;

  typedef enum logic [1:0] {
    EMIT_NONE  = 2'd0,
    EMIT_FIXED = 2'd1,
    EMIT_DATA  = 2'd2,
    EMIT_END   = 2'd3
  } emitE;

  typedef struct packed {
    logic memWr;
    logic lineClr;
    emitE emit;
    logic fixedLevel;
  } strobeT;

endpackage

// File: rtl/lsbCtrl.sv
module lsbCtrl
  import lsbPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 320,
  parameter int PLEN_W      = 13,
  parameter int CNT_W       = 9,
  parameter int ADDR_W      = 9,
  parameter int BIT_W       = 4,
  parameter int DIV_LOG_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              wrStb,
  input  logic              cmdSel,
  input  logic              dmaAck,
  input  logic              reqClk,
  input  logic              clkEn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  wordCount,
  output strobeT            strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [BIT_W-1:0]  bitSel,
  output logic              busy,
  output logic              intr,
  output logic              dmaReq,
  output logic              clkOut
);

  localparam int DIV_W = DIV_LOG_MAX;
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(DATA_W - 1);

  logic [5:0]        modeReg;
  logic [PLEN_W-1:0] plenReg;
  logic [CNT_W-1:0]  dmaLeft;
  logic              busyQ, intrQ, clkOutQ, reqPrev;
  logic [DIV_W-1:0]  divCnt;
  logic [PLEN_W-1:0] fixedLeft;
  logic [CNT_W-1:0]  wordsLeft;
  logic [ADDR_W-1:0] addrQ;
  logic [BIT_W-1:0]  bitQ;

  logic              revOrder, extMode, fixedLevel;
  logic [2:0]        divSel;
  logic [DIV_W-1:0]  ratioM1;
  logic              hostWr, cmdWr, memWr, dmaWr, goCmd, adv;
  logic [2:0]        cmdOp;
  emitE              emitNow;

  assign revOrder   = modeReg[0];
  assign extMode    = modeReg[1];
  assign divSel     = modeReg[4:2];
  assign fixedLevel = modeReg[5];

  always_comb begin
    if (divSel > 3'(DIV_LOG_MAX)) ratioM1 = '1;
    else ratioM1 = DIV_W'(((DIV_W+1)'(1) << divSel) - (DIV_W+1)'(1));
  end

  assign cmdOp  = dataIn[DATA_W-1 -: 3];
  assign hostWr = wrStb & ~busyQ;
  assign cmdWr  = hostWr & chipSel & cmdSel;
  assign memWr  = hostWr & ((chipSel & ~cmdSel) | dmaAck);
  assign dmaWr  = hostWr & dmaAck;
  assign goCmd  = cmdWr && (cmdOp == OP_GO);

  always_comb begin
    adv = 1'b0;
    if (busyQ && clkEn) begin
      if (extMode) adv = reqClk & ~reqPrev;
      else         adv = (divCnt == ratioM1);
    end
  end

  always_comb begin
    emitNow = EMIT_NONE;
    if (adv) begin
      if (fixedLeft != '0)      emitNow = EMIT_FIXED;
      else if (wordsLeft != '0) emitNow = EMIT_DATA;
      else                      emitNow = EMIT_END;
    end
  end

  assign strobe.memWr      = memWr;
  assign strobe.lineClr    = (emitNow == EMIT_END);
  assign strobe.emit       = emitNow;
  assign strobe.fixedLevel = fixedLevel;
  assign rdAddr = addrQ;
  assign bitSel = bitQ;
  assign busy   = busyQ;
  assign intr   = intrQ;
  assign dmaReq = (dmaLeft != '0);
  assign clkOut = clkOutQ;

  // command registers and DMA word count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      plenReg <= '0;
      dmaLeft <= '0;
    end else begin
      if (dmaWr && dmaLeft != '0) dmaLeft <= dmaLeft - 1'b1;
      if (cmdWr) begin
        case (cmdOp)
          OP_MODE: modeReg <= dataIn[5:0];
          OP_PLEN: plenReg <= dataIn[PLEN_W-1:0];
          OP_DMA:  dmaLeft <= dataIn[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // bit timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= 1'b0;
      divCnt  <= '0;
      clkOutQ <= 1'b0;
    end else begin
      reqPrev <= reqClk;
      if (goCmd) divCnt <= '0;
      else if (busyQ && clkEn && !extMode)
        divCnt <= (divCnt == ratioM1) ? '0 : divCnt + 1'b1;
      clkOutQ <= !extMode && (emitNow == EMIT_FIXED || emitNow == EMIT_DATA);
    end
  end

  // line sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      intrQ     <= 1'b0;
      fixedLeft <= '0;
      wordsLeft <= '0;
      addrQ     <= '0;
      bitQ      <= BIT_MAX;
    end else begin
      if (cmdWr) intrQ <= 1'b0;
      if (goCmd) begin
        busyQ     <= 1'b1;
        fixedLeft <= plenReg;
        wordsLeft <= wordCount;
        addrQ     <= revOrder ? ADDR_W'(wordCount - 1'b1) : '0;
        bitQ      <= BIT_MAX;
      end
      case (emitNow)
        EMIT_FIXED: fixedLeft <= fixedLeft - 1'b1;
        EMIT_DATA: begin
          if (bitQ == '0) begin
            bitQ      <= BIT_MAX;
            wordsLeft <= wordsLeft - 1'b1;
            addrQ     <= revOrder ? addrQ - 1'b1 : addrQ + 1'b1;
          end else begin
            bitQ <= bitQ - 1'b1;
          end
        end
        EMIT_END: begin
          busyQ <= 1'b0;
          intrQ <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lsbData.sv
module lsbData
  import lsbPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 320,
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CNT_W-1:0]  wordCount,
  output logic              serOut
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] lineMem [DEPTH];
  logic [CNT_W-1:0]  wrPtr;
  logic              hasRoom;
  logic [DATA_W-1:0] rdWord;

  assign hasRoom   = (wrPtr < DEPTH_C);
  assign wordCount = wrPtr;
  assign rdWord    = lineMem[rdAddr];

  always_ff @(posedge clk) begin
    if (strobe.memWr && hasRoom) lineMem[wrPtr[ADDR_W-1:0]] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPtr <= '0;
    else if (strobe.lineClr) wrPtr <= '0;
    else if (strobe.memWr && hasRoom) wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serOut <= 1'b0;
    else begin
      case (strobe.emit)
        EMIT_FIXED: serOut <= strobe.fixedLevel;
        EMIT_DATA:  serOut <= rdWord[bitSel];
        EMIT_END:   serOut <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lineSerializer.sv
module lineSerializer
  import lsbPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 320,
  parameter int PLEN_W      = 13,
  parameter int DIV_LOG_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              wrStb,
  input  logic              cmdSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dmaAck,
  output logic              dmaReq,
  input  logic              reqClk,
  input  logic              clkEn,
  output logic              serOut,
  output logic              clkOut,
  output logic              busy,
  output logic              intr
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(DATA_W);

  strobeT            strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic [BIT_W-1:0]  bitSel;
  logic [CNT_W-1:0]  wordCount;

  lsbCtrl #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PLEN_W(PLEN_W), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .BIT_W(BIT_W), .DIV_LOG_MAX(DIV_LOG_MAX)
  ) ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrStb(wrStb), .cmdSel(cmdSel),
    .dmaAck(dmaAck), .reqClk(reqClk), .clkEn(clkEn), .dataIn(dataIn),
    .wordCount(wordCount), .strobe(strobe), .rdAddr(rdAddr), .bitSel(bitSel),
    .busy(busy), .intr(intr), .dmaReq(dmaReq), .clkOut(clkOut)
  );

  lsbData #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)
  ) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .bitSel(bitSel),
    .dataIn(dataIn), .wordCount(wordCount), .serOut(serOut)
  );

endmodule

// File: rtl/lsbChecker.sv
module lsbChecker (
  input logic clk,
  input logic rstN,
  input logic chipSel,
  input logic wrStb,
  input logic cmdSel,
  input logic dmaAck,
  input logic clkEn,
  input logic dmaReq,
  input logic serOut,
  input logic clkOut,
  input logic busy,
  input logic intr
);

  a_r11_not_both: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && intr));

  a_r11_end_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> intr);

  a_r5_start_by_command: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrStb && chipSel && cmdSel));

  a_r10_gate_holds_output: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(serOut));

  a_r8_strobe_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    clkOut |-> busy);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serOut && !clkOut));

  a_r4_req_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaReq) |-> $past(wrStb && (dmaAck || (chipSel && cmdSel))));

endmodule

bind lineSerializer lsbChecker chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrStb(wrStb), .cmdSel(cmdSel),
  .dmaAck(dmaAck), .clkEn(clkEn), .dmaReq(dmaReq), .serOut(serOut),
  .clkOut(clkOut), .busy(busy), .intr(intr)
);

// File: tb/lineSerializer_test.sv
module lineSerializer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, wrStb = 1'b0, cmdSel = 1'b0, dmaAck = 1'b0;
  logic reqClk = 1'b0, clkEn = 1'b1;
  logic [15:0] dataIn = '0;
  logic dmaReq, serOut, clkOut, busy, intr;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lineSerializer uut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrStb(wrStb), .cmdSel(cmdSel),
    .dataIn(dataIn), .dmaAck(dmaAck), .dmaReq(dmaReq), .reqClk(reqClk),
    .clkEn(clkEn), .serOut(serOut), .clkOut(clkOut), .busy(busy), .intr(intr)
  );

  // behavioural reference model
  logic [15:0] mWords[$];
  bit          mBits[$];
  logic [5:0]  mMode = '0;
  int          mPlen = 0, mDma = 0, mCnt = 0;
  bit          mBusy = 0, mIntr = 0, mSer = 0, mClk = 0, mReqPrev = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mWords.delete(); mBits.delete();
      mMode = '0; mPlen = 0; mDma = 0; mCnt = 0;
      mBusy = 0; mIntr = 0; mSer = 0; mClk = 0; mReqPrev = 0;
    end else begin
      bit adv;
      int ratio;
      ratio = (mMode[4:2] > 3'd4) ? 16 : (1 << mMode[4:2]);
      adv = 0;
      if (mBusy && clkEn) begin
        if (!mMode[1]) begin
          if (mCnt == ratio - 1) begin adv = 1; mCnt = 0; end
          else mCnt++;
        end else adv = reqClk && !mReqPrev;
      end
      mReqPrev = reqClk;
      mClk = 0;
      if (adv) begin
        if (mBits.size() > 0) begin
          mSer = mBits.pop_front();
          mClk = !mMode[1];
        end else begin
          mBusy = 0; mIntr = 1; mSer = 0; mWords.delete();
        end
      end else if (!mBusy && wrStb) begin
        if ((chipSel && !cmdSel) || dmaAck)
          if (mWords.size() < 320) mWords.push_back(dataIn);
        if (dmaAck && mDma > 0) mDma--;
        if (chipSel && cmdSel) begin
          mIntr = 0;
          case (dataIn[15:13])
            3'd0: mMode = dataIn[5:0];
            3'd1: mPlen = int'(dataIn[12:0]);
            3'd2: mDma  = int'(dataIn[8:0]);
            3'd3: begin
              mBusy = 1; mCnt = 0; mBits.delete();
              for (int i = 0; i < mPlen; i++) mBits.push_back(mMode[5]);
              for (int k = 0; k < mWords.size(); k++) begin
                logic [15:0] w;
                w = mMode[0] ? mWords[mWords.size() - 1 - k] : mWords[k];
                for (int b = 15; b >= 0; b--) mBits.push_back(w[b]);
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(serOut == mSer, curReq, "serOut", serOut, mSer);
      check(clkOut == mClk, curReq, "clkOut", clkOut, mClk);
      check(busy == mBusy, curReq, "busy", busy, mBusy);
      check(intr == mIntr, curReq, "intr", intr, mIntr);
      check(dmaReq == (mDma != 0), curReq, "dmaReq", dmaReq, mDma != 0);
    end
  end

  task automatic memWrite(input logic [15:0] v);
    @(negedge clk); chipSel = 1; cmdSel = 0; wrStb = 1; dataIn = v;
    @(negedge clk); chipSel = 0; wrStb = 0;
  endtask

  task automatic cmdWrite(input logic [2:0] op, input logic [12:0] v);
    @(negedge clk); chipSel = 1; cmdSel = 1; wrStb = 1; dataIn = {op, v};
    @(negedge clk); chipSel = 0; cmdSel = 0; wrStb = 0;
  endtask

  task automatic dmaWrite(input logic [15:0] v);
    @(negedge clk); dmaAck = 1; wrStb = 1; dataIn = v;
    @(negedge clk); dmaAck = 0; wrStb = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!busy && !intr && !dmaReq && !serOut && !clkOut, "R1", "reset outputs",
          {busy, intr, dmaReq, serOut, clkOut}, 0);
    rstN = 1;
    @(negedge clk);

    // R2 R5 R6 forward order, ones prefix, ratio 1
    curReq = "R6";
    cmdWrite(3'd0, 13'b100000);
    cmdWrite(3'd1, 13'd5);
    memWrite(16'hA5C3); memWrite(16'h0001); memWrite(16'h8000);
    cmdWrite(3'd3, 13'd0);
    check(busy == 1, "R5", "busy after start", busy, 1);
    waitIdle();
    check(intr == 1, "R11", "intr at end", intr, 1);

    // R11 intr cleared by a command; R7 reverse order, zeros prefix, ratio 4
    curReq = "R7";
    cmdWrite(3'd0, 13'b001001);
    check(intr == 0, "R11", "intr cleared", intr, 0);
    cmdWrite(3'd1, 13'd3);
    memWrite(16'h1234); memWrite(16'hF00D);
    cmdWrite(3'd3, 13'd0);
    curReq = "R12";
    memWrite(16'hFFFF);
    cmdWrite(3'd0, 13'b000010);
    cmdWrite(3'd3, 13'd0);
    waitIdle();

    // R8 divider field 6 acts as 16
    curReq = "R8";
    cmdWrite(3'd0, 13'b011000);
    cmdWrite(3'd1, 13'd0);
    memWrite(16'hC001);
    cmdWrite(3'd3, 13'd0);
    waitIdle();

    // R9 R10 external clock with stuttering enable
    curReq = "R9";
    cmdWrite(3'd0, 13'b000011);
    cmdWrite(3'd1, 13'd4);
    memWrite(16'h6A59); memWrite(16'h00FF);
    cmdWrite(3'd3, 13'd0);
    for (int k = 0; busy && k < 2000; k++) begin
      @(negedge clk);
      curReq = (k % 7 == 3) ? "R10" : "R9";
      clkEn = (k % 7 != 3);
      if (k % 2 == 0) reqClk = ~reqClk;
    end
    clkEn = 1; reqClk = 0;
    curReq = "R9";
    check(busy == 0, "R9", "external line done", busy, 0);

    // R4 DMA loading
    curReq = "R4";
    cmdWrite(3'd0, 13'b000000);
    cmdWrite(3'd2, 13'd0);
    check(dmaReq == 0, "R4", "zero count no request", dmaReq, 0);
    cmdWrite(3'd2, 13'd3);
    check(dmaReq == 1, "R4", "request raised", dmaReq, 1);
    dmaWrite(16'hBEEF); dmaWrite(16'h0F0F);
    check(dmaReq == 1, "R4", "request held", dmaReq, 1);
    dmaWrite(16'h7001);
    check(dmaReq == 0, "R4", "request dropped", dmaReq, 0);
    cmdWrite(3'd3, 13'd0);
    waitIdle();

    // R3 full line: 322 writes, only 320 kept
    curReq = "R3";
    for (int i = 0; i < 322; i++) memWrite(16'(i * 257) ^ 16'h5A5A);
    cmdWrite(3'd3, 13'd0);
    waitIdle();

    // R11 empty line with prefix only
    curReq = "R11";
    cmdWrite(3'd0, 13'b100100);
    cmdWrite(3'd1, 13'd2);
    cmdWrite(3'd3, 13'd0);
    waitIdle();
    check(intr == 1 && serOut == 0, "R11", "empty line end", {intr, serOut}, 2);

    // R1 reset returns to idle mid-line
    curReq = "R1";
    memWrite(16'hFFFF);
    cmdWrite(3'd3, 13'd0);
    repeat (4) @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check(!busy && !intr && !serOut, "R1", "reset mid-line", {busy, intr, serOut}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule